// File: doc/BRIEF.md
# MII Elastic Buffer

This block carries receive-side MII nibbles, each with its data-valid and error flag, across to the transmit side of a second MII interface. Both sides run on the same clock, and each is paced by its own clock-enable pulse. Because the two enable streams drift slightly against each other, a frame's nibbles are queued in a small register-based shift FIFO. The transmit side holds back a frame until enough nibbles have built up to cover that drift.

Transmission of a frame begins once the fill level reaches `WATERMARK`. A frame that ends before reaching that level starts as soon as its receive data-valid drops. After the input frame ends, the buffer drains completely, then releases transmit enable. If the buffer runs dry mid-frame, or a nibble arrives while it is full, the outgoing frame is marked with the error output. The error output can be removed by parameter for transmit sides that never carry an error.

Top module: `mii_elastic_buf`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the buffer and drives `tx_en`, `txd` and `tx_er` low from the next cycle. No frame is emitted afterwards until new input arrives.
- R2: A nibble is taken in only at an edge where `rx_ce` and `rx_dv` are both high. The outputs change only at edges where `tx_ce` is high. Nibbles leave in the order they arrived, and none is lost or duplicated when no error occurs.
- R3: `tx_en` rises only once the fill level has reached `WATERMARK`, unless the input frame has already ended.
- R4: A frame shorter than `WATERMARK` nibbles is sent intact once `rx_dv` has been sampled low at an `rx_ce` edge.
- R5: After the input frame ends, the remaining nibbles are sent. `tx_en` falls at the first `tx_ce` edge that finds the buffer empty.
- R6: If the buffer is empty at a `tx_ce` edge while a frame is being sent and the input frame is still active, `tx_en` stays high and `tx_er` is high from then until the end of that frame.
- R7: A nibble written while the buffer holds `DEPTH` entries, with no read at the same edge, is dropped. `tx_er` is then high on the remaining nibbles of the outgoing frame.
- R8: An input nibble sampled with `rx_er` high leaves with `tx_er` high.
- R9: With `HAS_ERR` = 0, `tx_er` is constantly low.
- R10: The fill level never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_ce | input | 1 | Receive-side clock enable |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| tx_ce | input | 1 | Transmit-side clock enable |
| txd | output | 4 | Transmit data nibble |
| tx_en | output | 1 | Transmit enable (frame valid) |
| tx_er | output | 1 | Transmit error, tied low when `HAS_ERR` = 0 |

## Verification
A fill counter that is off by one shows up at the ports on the very next `tx_ce` pulse. It appears as a repeated or missing nibble, or as `tx_en` rising one write too early compared with the number of nibbles the bench has already supplied. A stuck frame-activity flag shows either as a short frame that is never sent or as a frame tail cut off, visible at the end of the first frame. A wrong error sticky bit shows as `tx_er` on clean frames, or as missing `tx_er` after a forced underflow or overflow, within the same frame.

// File: rtl/mii_elastic_buf.sv
module mii_elastic_buf #(
  parameter int DEPTH     = 16,
  parameter int WATERMARK = 8,
  parameter bit HAS_ERR   = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_ce,
  input  logic [3:0] rxd,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic       tx_ce,
  output logic [3:0] txd,
  output logic       tx_en,
  output logic       tx_er
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [4:0]    stg [DEPTH];
  logic [CW-1:0] cnt;
  logic          rx_act, sending, sticky, er_q;

  wire           push  = rx_ce && rx_dv;
  wire           start = !sending && cnt != '0 && (cnt >= CW'(WATERMARK) || !rx_act);
  wire           pop   = tx_ce && (sending || start) && cnt != '0;
  wire           ovf   = push && cnt == CW'(DEPTH) && !pop;
  wire           wr    = push && !ovf;
  wire [CW-1:0]  widx  = cnt - CW'(pop);
  wire [4:0]     din   = {rx_er, rxd};

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    wire hit = wr && widx == CW'(i);
    if (i < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk)
        if (hit) stg[i] <= din;
        else if (pop) stg[i] <= stg[i+1];
    end else begin : g_last
      always_ff @(posedge clk)
        if (hit) stg[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rx_act <= 1'b0;
    end else begin
      cnt <= cnt + CW'(wr) - CW'(pop);
      if (rx_ce) rx_act <= rx_dv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sending <= 1'b0;
      sticky  <= 1'b0;
      tx_en   <= 1'b0;
      txd     <= 4'h0;
      er_q    <= 1'b0;
    end else begin
      if (ovf) sticky <= 1'b1;
      if (tx_ce) begin
        if (pop) begin
          sending <= 1'b1;
          tx_en   <= 1'b1;
          txd     <= stg[0][3:0];
          er_q    <= stg[0][4] | sticky | ovf;
        end else if (sending && rx_act) begin
          tx_en  <= 1'b1;
          er_q   <= 1'b1;
          sticky <= 1'b1;
        end else if (sending) begin
          sending <= 1'b0;
          tx_en   <= 1'b0;
          txd     <= 4'h0;
          er_q    <= 1'b0;
          sticky  <= ovf;
        end
      end
    end
  end

  assign tx_er = HAS_ERR ? er_q : 1'b0;
endmodule

module mii_elastic_buf_chk #(
  parameter int DEPTH     = 16,
  parameter int WATERMARK = 8,
  parameter bit HAS_ERR   = 1'b1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tx_ce,
  input logic [3:0]                   txd,
  input logic                         tx_en,
  input logic                         tx_er,
  input logic                         rx_act,
  input logic [$clog2(DEPTH+1)-1:0]   cnt
);
  a_r1_reset_empties: assert property (@(posedge clk)
    rst |=> (!tx_en && cnt == '0));

  a_r2_tx_paced: assert property (@(posedge clk) disable iff (rst)
    !tx_ce |=> ($stable(tx_en) && $stable(txd) && $stable(tx_er)));

  a_r3_watermark_start: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> ($past(cnt) >= WATERMARK || !$past(rx_act)));

  a_r5_end_when_drained: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> ($past(cnt) == '0 && !$past(rx_act)));

  a_r9_no_err_pin: assert property (@(posedge clk) disable iff (rst)
    !HAS_ERR |-> !tx_er);

  a_r10_no_overfill: assert property (@(posedge clk) disable iff (rst)
    cnt <= DEPTH);
endmodule

bind mii_elastic_buf mii_elastic_buf_chk #(
  .DEPTH(DEPTH), .WATERMARK(WATERMARK), .HAS_ERR(HAS_ERR)
) u_chk (
  .clk(clk), .rst(rst), .tx_ce(tx_ce), .txd(txd), .tx_en(tx_en),
  .tx_er(tx_er), .rx_act(rx_act), .cnt(cnt)
);

// File: tb/test_mii_elastic_buf.sv
`timescale 1ns/1ps
module test_mii_elastic_buf;
  localparam int DEPTH = 16;
  localparam int WM    = 8;
  localparam int NV    = 7;
  // {length[11:0], rx divisor[3:0], tx divisor[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {12'd20, 4'd1, 4'd1}, {12'd12, 4'd2, 4'd3}, {12'd16, 4'd3, 4'd2},
    {12'd3,  4'd1, 4'd1}, {12'd5,  4'd4, 4'd4}, {12'd40, 4'd2, 4'd2},
    {12'd8,  4'd1, 4'd2}};

  logic clk = 0, rst = 1;
  logic rx_ce = 0, rx_dv = 0, rx_er = 0, tx_ce = 0;
  logic [3:0] rxd = 0;
  logic [3:0] txd, txd2;
  logic tx_en, tx_er, tx_en2, tx_er2;

  always #4 clk = ~clk;

  mii_elastic_buf #(.DEPTH(DEPTH), .WATERMARK(WM)) i_mii_elastic_buf (
    .clk(clk), .rst(rst), .rx_ce(rx_ce), .rxd(rxd), .rx_dv(rx_dv),
    .rx_er(rx_er), .tx_ce(tx_ce), .txd(txd), .tx_en(tx_en), .tx_er(tx_er));

  mii_elastic_buf #(.DEPTH(DEPTH), .WATERMARK(WM), .HAS_ERR(1'b0)) i_mii_elastic_buf_noerr (
    .clk(clk), .rst(rst), .rx_ce(rx_ce), .rxd(rxd), .rx_dv(rx_dv),
    .rx_er(rx_er), .tx_ce(tx_ce), .txd(txd2), .tx_en(tx_en2), .tx_er(tx_er2));

  int checks = 0, errors = 0;
  logic [3:0] stim [256];
  logic       stim_er [256];
  int st_len = 0, st_idx = 0, rxdiv = 1, txdiv = 1, rxc = 0, txc = 0;
  logic [3:0] rec_d [512];
  logic       rec_e [512];
  int rec_n = 0, wr_at_start = -1;
  logic noerr_bad = 0;

  always @(negedge clk) begin
    if (tx_ce && tx_en) begin
      if (rec_n == 0) wr_at_start = st_idx;
      if (rec_n < 512) begin rec_d[rec_n] = txd; rec_e[rec_n] = tx_er; end
      rec_n++;
    end
    if (tx_er2) noerr_bad = 1;
    txc = (txc + 1 >= txdiv) ? 0 : txc + 1;
    rxc = (rxc + 1 >= rxdiv) ? 0 : rxc + 1;
    tx_ce = (txc == 0);
    rx_ce = (rxc == 0);
    if (rx_ce) begin
      if (st_idx < st_len) begin
        rxd = stim[st_idx]; rx_er = stim_er[st_idx]; rx_dv = 1; st_idx++;
      end else begin
        rx_dv = 0; rx_er = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int len, input int rd, input int td, input int erpos, input int wait_cyc);
    rxdiv = rd; txdiv = td;
    for (int i = 0; i < len; i++) begin
      stim[i] = 4'((i * 7 + len) & 15);
      stim_er[i] = (i == erpos);
    end
    rec_n = 0; wr_at_start = -1; st_idx = 0;
    @(negedge clk); st_len = len;
    repeat (wait_cyc) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx_en == 0 && txd == 0 && tx_er == 0, "R1", tx_en, 0);
    rst = 0;

    for (int v = 0; v < NV; v++) begin
      int len, rd, td, bad, anyerr;
      len = int'(VEC[v][19:8]); rd = int'(VEC[v][7:4]); td = int'(VEC[v][3:0]);
      run(len, rd, td, -1, (len + 20) * 8);
      bad = 0; anyerr = 0;
      for (int i = 0; i < len && i < rec_n; i++) begin
        if (rec_d[i] != stim[i]) bad++;
        if (rec_e[i]) anyerr++;
      end
      chk(rec_n == len, "R2 count", rec_n, len);
      chk(bad == 0, "R2 data order", bad, 0);
      chk(anyerr == 0, "R6/R7 no spurious error", anyerr, 0);
      chk(tx_en == 0, "R5 frame closed", tx_en, 0);
      if (len >= WM) chk(wr_at_start >= WM, "R3 watermark", wr_at_start, WM);
      else           chk(wr_at_start == len, "R4 short frame", wr_at_start, len);
      st_len = 0;
    end

    // R8: input error carried on its nibble; R9: no-error variant stays low
    noerr_bad = 0;
    run(12, 1, 1, 5, 200);
    chk(rec_n == 12 && rec_e[5] == 1, "R8 error nibble", int'(rec_e[5]), 1);
    chk(rec_e[4] == 0 && rec_e[6] == 0, "R8 neighbours clean", int'(rec_e[6]), 0);
    chk(noerr_bad == 0, "R9 tx_er tied low", int'(noerr_bad), 0);
    st_len = 0;

    // R6: underflow mid-frame, error sticks to end of frame
    begin
      int first, gap;
      run(40, 4, 1, -1, 400);
      first = -1; gap = 0;
      for (int i = 0; i < rec_n && i < 512; i++) begin
        if (rec_e[i] && first < 0) first = i;
        if (first >= 0 && !rec_e[i]) gap++;
      end
      chk(first >= WM, "R6 underflow flagged", first, WM);
      chk(gap == 0, "R6 error held to frame end", gap, 0);
      chk(tx_en == 0, "R5 underflowed frame closed", tx_en, 0);
      st_len = 0;
    end

    // R7: overflow drops nibbles and flags the frame
    begin
      int anyerr, bad;
      run(64, 1, 4, -1, 800);
      anyerr = 0; bad = 0;
      for (int i = 0; i < rec_n && i < 512; i++) if (rec_e[i]) anyerr++;
      for (int i = 0; i < WM; i++) if (rec_d[i] != stim[i]) bad++;
      chk(rec_n < 64, "R7 nibbles dropped", rec_n, 63);
      chk(anyerr > 0, "R7 overflow flagged", anyerr, 1);
      chk(bad == 0, "R7 head intact", bad, 0);
      chk(rec_e[rec_n-1] == 1, "R7 error to frame end", int'(rec_e[rec_n-1]), 1);
      st_len = 0;
    end

    // R1: reset mid-frame empties the buffer
    rxdiv = 1; txdiv = 8;
    rec_n = 0; st_idx = 0;
    @(negedge clk); st_len = 30;
    repeat (12) @(posedge clk);
    @(negedge clk); st_len = 0; rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tx_en == 0 && tx_er == 0, "R1 reset mid-frame", tx_en, 0);
    rst = 0; rec_n = 0;
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(rec_n == 0, "R1 nothing after reset", rec_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule